// File: doc/BRIEF.md
# Floating-Point Exception Status Updater

This block keeps the five-bit current-exception field and the five-bit accrued-exception field of a floating-point status register. It also raises a trap request. It acts at instruction commit. Each clock it sees at most one commit event. A commit event carries a kind code, a trap-type code, an exception report from the floating-point unit, data loaded from memory and the trap-enable mask.

A fixed priority decides how the event changes the fields:

- A committing status load overwrites both fields from the load data.
- A trap-free floating-point operation refreshes the current field from the unit's report.
- An operation that reports an IEEE exception keeps exactly one flag.
- Operations that are unfinished or unimplemented change nothing.
- Any other event also changes nothing.

Trapping outcomes come from a trap-enabled exception or an IEEE exception report. They move a two-state machine from `ST_CALM` to `ST_TRAP` for one cycle, and `trap_req` is high while the machine is in `ST_TRAP`. The machine has these transitions:

- `CALM->TRAP`: the sampled commit is trapping.
- `TRAP->TRAP`: the sampled commit is trapping.
- `TRAP->CALM`: the sampled commit is not trapping.
- `CALM->CALM`: the sampled commit is not trapping.

Top module: `fp_exc_status_updater`

## Requirements
- R1: While reset is asserted (rst_n low), and after it, until the first commit event, cexc, aexc and trap_req are all 0.
- R2: A valid commit whose kind is 1 (32-bit status load) or 2 (64-bit status load) sets cexc to load_data[4:0] and aexc to load_data[9:5] at the next clock edge. This happens whatever the trap type, exception report and mask are, and it raises no trap. Exception bit order in every 5-bit field is invalid at bit 4, overflow at bit 3, underflow at bit 2, divide-by-zero at bit 1 and inexact at bit 0.
- R3: A valid commit of kind 3 (floating-point operation) with trap type 0 (none), whose report has no bit that is enabled in the mask, sets cexc equal to the report. Bits that are absent from the report are cleared. The same commit sets aexc to the old aexc ORed with the report.
- R4: A kind-3 commit with trap type 0 whose report shares a set bit with the mask sets cexc to the report, leaves aexc unchanged and raises a trap.
- R5: A kind-3 commit with trap type 1 (IEEE exception) and a non-zero report sets cexc to a single bit, which is the highest-ranked set bit of the report (invalid ranks highest, inexact lowest). It leaves aexc unchanged and raises a trap. With a zero report the commit changes nothing and raises no trap.
- R6: A kind-3 commit with trap type 2 (unfinished), trap type 3 (unimplemented) or any other code from 4 to 7 leaves cexc and aexc unchanged and raises no trap.
- R7: A commit of kind 0, or any cycle with commit_valid low, leaves cexc and aexc unchanged and raises no trap.
- R8: trap_req is high for exactly the one cycle that follows each trapping commit and is low in every other cycle. Back-to-back trapping commits keep it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| commit_valid | input | 1 | A commit event is present this cycle |
| commit_kind | input | 2 | 0 other, 1 32-bit status load, 2 64-bit status load, 3 FP operation |
| trap_type | input | 3 | 0 none, 1 IEEE exception, 2 unfinished, 3 unimplemented |
| fpu_exc | input | 5 | Exception report from the FP unit |
| load_data | input | 10 | Loaded status bits: [9:5] accrued, [4:0] current |
| trap_mask | input | 5 | Trap-enable bits, same bit order |
| cexc | output | 5 | Current-exception field |
| aexc | output | 5 | Accrued-exception field |
| trap_req | output | 1 | One-cycle trap request |

## Verification
Every result of a commit is registered once. The commit is sampled on a rising edge, and cexc, aexc and trap_req show its effect from that same edge until the next one. The bench drives each event just after a falling edge. It advances its reference model and compares all three outputs at the following falling edge, so each check lands exactly one edge after the commit was sampled. A trap pulse is confirmed gone one falling edge later still.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_LOAD,
        ACT_REFRESH,
        ACT_FLAG
    } act_t;

    typedef enum logic {
        ST_CALM,
        ST_TRAP
    } tstate_t;

    localparam logic [1:0] KIND_OTHER = 2'd0;
    localparam logic [1:0] KIND_LDW   = 2'd1;
    localparam logic [1:0] KIND_LDX   = 2'd2;
    localparam logic [1:0] KIND_FPOP  = 2'd3;
endpackage

// File: rtl/fpx_classify.sv
module fpx_classify
    import fpx_pkg::*;
#(
    parameter int TT_W  = 3,
    parameter int EXC_W = 5
) (
    input  logic             commit_valid,
    input  logic [1:0]       commit_kind,
    input  logic [TT_W-1:0]  trap_type,
    input  logic [EXC_W-1:0] fpu_exc,
    output act_t             act
);
    localparam logic [TT_W-1:0] TT_NONE = '0;
    localparam logic [TT_W-1:0] TT_IEEE = TT_W'(1);

    always_comb begin
        act = ACT_HOLD;
        if (commit_valid) begin
            unique case (commit_kind)
                KIND_LDW, KIND_LDX: act = ACT_LOAD;
                KIND_FPOP: begin
                    if (trap_type == TT_NONE) begin
                        act = ACT_REFRESH;
                    end else if (trap_type == TT_IEEE && |fpu_exc) begin
                        act = ACT_FLAG;
                    end
                end
                KIND_OTHER: act = ACT_HOLD;
            endcase
        end
    end
endmodule

// File: rtl/fpx_pick.sv
module fpx_pick #(
    parameter int EXC_W = 5
) (
    input  logic [EXC_W-1:0] report,
    output logic [EXC_W-1:0] single
);
    logic taken;

    always_comb begin
        single = '0;
        taken  = 1'b0;
        for (int i = EXC_W - 1; i >= 0; i--) begin
            if (report[i] && !taken) begin
                single[i] = 1'b1;
                taken     = 1'b1;
            end
        end
    end
endmodule

// File: rtl/fp_exc_status_updater.sv
module fp_exc_status_updater
    import fpx_pkg::*;
#(
    parameter int EXC_W = 5,
    parameter int TT_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit_valid,
    input  logic [1:0]         commit_kind,
    input  logic [TT_W-1:0]    trap_type,
    input  logic [EXC_W-1:0]   fpu_exc,
    input  logic [2*EXC_W-1:0] load_data,
    input  logic [EXC_W-1:0]   trap_mask,
    output logic [EXC_W-1:0]   cexc,
    output logic [EXC_W-1:0]   aexc,
    output logic               trap_req
);
    localparam int LD_W = 2 * EXC_W;

    act_t             act;
    logic [EXC_W-1:0] flag_bit;
    logic             enabled_hit;
    logic             trap_hit;
    tstate_t          state;
    tstate_t          state_nxt;

    fpx_classify #(.TT_W(TT_W), .EXC_W(EXC_W)) u_classify (
        .commit_valid (commit_valid),
        .commit_kind  (commit_kind),
        .trap_type    (trap_type),
        .fpu_exc      (fpu_exc),
        .act          (act)
    );

    fpx_pick #(.EXC_W(EXC_W)) u_pick (
        .report (fpu_exc),
        .single (flag_bit)
    );

    assign enabled_hit = |(fpu_exc & trap_mask);
    assign trap_hit    = (act == ACT_FLAG) || (act == ACT_REFRESH && enabled_hit);

    // trap state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_CALM;
        else        state <= state_nxt;
    end

    always_comb begin
        unique case (state)
            ST_CALM: state_nxt = trap_hit ? ST_TRAP : ST_CALM;
            ST_TRAP: state_nxt = trap_hit ? ST_TRAP : ST_CALM;
        endcase
    end

    assign trap_req = (state == ST_TRAP);

    // exception fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cexc <= '0;
            aexc <= '0;
        end else begin
            unique case (act)
                ACT_LOAD: begin
                    cexc <= load_data[EXC_W-1:0];
                    aexc <= load_data[LD_W-1:EXC_W];
                end
                ACT_REFRESH: begin
                    cexc <= fpu_exc;
                    if (!enabled_hit) aexc <= aexc | fpu_exc;
                end
                ACT_FLAG: cexc <= flag_bit;
                ACT_HOLD: ;
            endcase
        end
    end

    // R2
    a_r2_load_writes: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_valid && (commit_kind == KIND_LDW || commit_kind == KIND_LDX))
        |=> (cexc == $past(load_data[EXC_W-1:0]) && aexc == $past(load_data[LD_W-1:EXC_W]) && !trap_req));

    // R3
    a_r3_accrue: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_valid && commit_kind == KIND_FPOP && trap_type == '0 && (fpu_exc & trap_mask) == '0)
        |=> (cexc == $past(fpu_exc) && aexc == ($past(aexc) | $past(fpu_exc))));

    // R4
    a_r4_enabled_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_valid && commit_kind == KIND_FPOP && trap_type == '0 && (fpu_exc & trap_mask) != '0)
        |=> (trap_req && $stable(aexc)));

    // R5
    a_r5_single_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_valid && commit_kind == KIND_FPOP && trap_type == TT_W'(1) && fpu_exc != '0)
        |=> ($countones(cexc) == 1 && (cexc & $past(fpu_exc)) == cexc && trap_req && $stable(aexc)));

    // R6
    a_r6_unfinished_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_valid && commit_kind == KIND_FPOP && trap_type >= TT_W'(2))
        |=> ($stable(cexc) && $stable(aexc) && !trap_req));

    // R7
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit_valid || commit_kind == KIND_OTHER)
        |=> ($stable(cexc) && $stable(aexc) && !trap_req));
endmodule

// File: tb/fp_exc_status_updater_tb_top.sv
`timescale 1ns/1ps
module fp_exc_status_updater_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       commit_valid;
    logic [1:0] commit_kind;
    logic [2:0] trap_type;
    logic [4:0] fpu_exc;
    logic [9:0] load_data;
    logic [4:0] trap_mask;
    logic [4:0] cexc;
    logic [4:0] aexc;
    logic       trap_req;

    int n_checks = 0;
    int n_fail   = 0;
    logic [4:0] m_c = '0;
    logic [4:0] m_a = '0;
    logic       m_t = 1'b0;

    always #5 clk = ~clk;

    fp_exc_status_updater dut_i (
        .clk(clk), .rst_n(rst_n), .commit_valid(commit_valid),
        .commit_kind(commit_kind), .trap_type(trap_type), .fpu_exc(fpu_exc),
        .load_data(load_data), .trap_mask(trap_mask),
        .cexc(cexc), .aexc(aexc), .trap_req(trap_req)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [4:0] top_bit(input logic [4:0] r);
        for (int i = 4; i >= 0; i--) if (r[i]) return 5'(1 << i);
        return 5'd0;
    endfunction

    task automatic step(input logic v, input logic [1:0] k, input logic [2:0] t,
                        input logic [4:0] e, input logic [9:0] d, input logic [4:0] m);
        string tag;
        commit_valid = v; commit_kind = k; trap_type = t;
        fpu_exc = e; load_data = d; trap_mask = m;
        @(negedge clk);
        m_t = 1'b0;
        if (v && (k == 2'd1 || k == 2'd2)) begin
            m_c = d[4:0]; m_a = d[9:5]; tag = "R2";
        end else if (v && k == 2'd3 && t == 3'd0) begin
            m_c = e;
            if ((e & m) != 0) begin m_t = 1'b1; tag = "R4"; end
            else begin m_a = m_a | e; tag = "R3"; end
        end else if (v && k == 2'd3 && t == 3'd1) begin
            tag = "R5";
            if (e != 0) begin m_c = top_bit(e); m_t = 1'b1; end
        end else if (v && k == 2'd3) begin
            tag = "R6";
        end else begin
            tag = "R7";
        end
        chk(tag, "cexc", int'(cexc), int'(m_c));
        chk(tag, "aexc", int'(aexc), int'(m_a));
        chk({"R8/", tag}, "trap_req", int'(trap_req), int'(m_t));
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; commit_valid = 1'b0; commit_kind = '0; trap_type = '0;
        fpu_exc = '0; load_data = '0; trap_mask = '0;
        @(negedge clk); @(negedge clk);
        chk("R1", "cexc", int'(cexc), 0);
        chk("R1", "aexc", int'(aexc), 0);
        chk("R1", "trap_req", int'(trap_req), 0);
        // a commit while reset is held must not land
        commit_valid = 1'b1; commit_kind = 2'd1; load_data = 10'h3FF;
        @(negedge clk);
        chk("R1", "cexc", int'(cexc), 0);
        chk("R1", "aexc", int'(aexc), 0);
        commit_valid = 1'b0;
        rst_n = 1'b1;
        step(0, 2'd0, 3'd0, 5'd0, 10'd0, 5'd0);               // R7 idle after reset
        step(1, 2'd3, 3'd0, 5'b00101, 10'd0, 5'b00000);       // R3 accrue
        step(1, 2'd3, 3'd0, 5'b01000, 10'd0, 5'b00000);       // R3 absent bits cleared
        step(1, 2'd3, 3'd0, 5'b10000, 10'd0, 5'b10000);       // R4 enabled trap
        step(1, 2'd3, 3'd0, 5'b00010, 10'd0, 5'b00010);       // R4/R8 back-to-back
        step(0, 2'd3, 3'd0, 5'b11111, 10'd0, 5'd0);           // R8 pulse ends, R7
        step(1, 2'd3, 3'd1, 5'b01110, 10'd0, 5'd0);           // R5 picks overflow
        step(1, 2'd3, 3'd1, 5'b00000, 10'd0, 5'd0);           // R5 zero report
        step(1, 2'd3, 3'd2, 5'b11111, 10'd0, 5'd0);           // R6 unfinished
        step(1, 2'd3, 3'd3, 5'b11111, 10'd0, 5'd0);           // R6 unimplemented
        step(1, 2'd3, 3'd6, 5'b11111, 10'd0, 5'd0);           // R6 other code
        step(1, 2'd0, 3'd0, 5'b11111, 10'h3FF, 5'd0);         // R7 kind 0
        step(1, 2'd1, 3'd1, 5'b11111, 10'b10101_01010, 5'h1F); // R2 32-bit load
        step(1, 2'd2, 3'd0, 5'b11111, 10'b00011_11000, 5'h1F); // R2 64-bit load
        step(1, 2'd3, 3'd0, 5'b00000, 10'd0, 5'h1F);          // R3 zero report clears
        for (int i = 0; i < 2000; i++) begin
            step(1'($urandom_range(0, 3) != 0), 2'($urandom), 3'($urandom_range(0, 4)),
                 5'($urandom), 10'($urandom), 5'($urandom_range(0, 2) == 0 ? $urandom : 0));
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule